// File: doc/BRIEF.md
# Field-Relative Enable Strobe Sequencer

This block times the memory strobes of a video line-rate processor. It does not touch pixel data. A rising edge on `field_start` opens a field. From that edge the block counts system clock cycles within the current input line and whole input lines, where each rising edge of `line_ref` starts a new line. From these two counts it drives four strobes:

| Strobe | Fixed base offset | Line wait | Added programmable shift |
|---|---|---|---|
| `rd_en_c` (read enable for memory bus C) | 62 cycles | none | `shift_c` |
| `rd_en_a` (read enable for memory bus A) | 93 cycles | none | `shift_a` |
| `out_active` (main output data active) | 147 cycles | after 3 lines | none |
| `wr_en_b` (write enable for memory bus B) | 159 cycles | after 4 lines | `shift_b` |

The three-line algorithmic delay of the datapath shows in these numbers. Output starts while the fourth input line is read. Writing to bus B starts one line after that.

Each strobe goes high at its offset, counted in cycles from the start of the line. It stays high for `active_len` cycles and fires again at the same offset in every later line. A strobe with a line wait stays silent until that many line edges have passed in the field.

The block has two kinds of state machine:

- **Shared timebase.** It has two states:
  - TB_IDLE holds after reset.
  - TB_RUN is entered on the first field edge, and each later field edge re-enters it.
- **Channel, one per strobe.** It has four states:
  - CH_IDLE holds until the first field.
  - CH_ARM waits for the offset and the line count.
  - CH_ON drives the strobe high.
  - CH_REST means this line's pulse is done.

The channel transitions are:

- IDLE to ARM on a field edge.
- ARM to ON when the offset is reached and enough lines have passed.
- ARM to REST on the same condition when the length is zero.
- ON to REST when the pulse has lasted its length.
- ON, REST or ARM to ARM (or straight to ON) on any line or field edge.

Top module: `field_strobe_seq`

## Requirements
- R1: After reset all four strobes are low. They stay low, whatever `line_ref` does, until the first rising edge of `field_start`.
- R2: A field edge is the first clock edge at which `field_start` is sampled high after being sampled low. Holding it high does not start a new field. At the field edge the cycle-in-line count and the line count both restart from zero.
- R3: `rd_en_c` is high after clock edge E+62+`shift_c`, where E is the field edge, and low after the edge before it. This applies in line 0 and at the same offset from each later line edge.
- R4: `rd_en_a` behaves the same way, at offset 93+`shift_a`.
- R5: `out_active` is never high before the third `line_ref` rising edge of the field. From that line on, it rises 147 cycles after each line edge.
- R6: `wr_en_b` is never high before the fourth line edge of the field. From that line on, it rises 159+`shift_b` cycles after each line edge.
- R7: Each pulse lasts exactly `active_len` cycles. A length of 0 means the strobe never asserts.
- R8: A `line_ref` rising edge is the first clock edge at which it is sampled high after being sampled low. Each such edge restarts the cycle count, and every strobe re-arms at its offset in the new line.
- R9: A line edge that arrives while a strobe is high ends that pulse. The strobe then waits for its offset in the new line.
- R10: The shifts and `active_len` are captured at the field edge. Changes made later in the field do not alter any strobe before the next field edge.
- R11: A field edge during an active field restarts all counting. Every strobe is low after that edge and is retimed from the new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_start | input | 1 | Field start reference; its rising edge opens a field |
| line_ref | input | 1 | Horizontal line reference; its rising edge starts a line |
| shift_a | input | 8 | Extra delay for the bus A read enable, in cycles |
| shift_b | input | 8 | Extra delay for the bus B write enable, in cycles |
| shift_c | input | 8 | Extra delay for the bus C read enable, in cycles |
| active_len | input | 12 | Strobe pulse length, in cycles |
| rd_en_a | output | 1 | Read enable for memory bus A |
| rd_en_c | output | 1 | Read enable for memory bus C |
| wr_en_b | output | 1 | Write enable for memory bus B |
| out_active | output | 1 | Main output data active |

## Verification
All strobes are registered.

- A strobe whose offset is O is first visible after the O-th clock edge that follows the field or line edge that restarted the count.
- It falls after the edge O+`active_len`.
- An input change becomes an edge only at the clock edge that samples it.

The bench drives inputs on the falling clock edge and advances its own count model at that moment, as the next rising edge will. At the following falling edge it compares all four strobes against that model, so every result is checked in the one cycle where it is due. Directed fields cover these cases:

- the shift extremes 0 and 255
- lengths 0, 1 and longer than a line
- shift changes in the middle of a field
- a field restarted in the middle of a field

Seeded random fields vary line length, pulse widths and settings.

// File: rtl/fss_pkg.sv
`timescale 1ns/1ps
package fss_pkg;
    typedef enum logic [1:0] {
        CH_IDLE,
        CH_ARM,
        CH_ON,
        CH_REST
    } ch_state_e;

    typedef enum logic {
        TB_IDLE,
        TB_RUN
    } tb_state_e;

    localparam int NCH    = 4;
    localparam int IDX_C  = 0;
    localparam int IDX_A  = 1;
    localparam int IDX_O  = 2;
    localparam int IDX_B  = 3;
endpackage

// File: rtl/fss_timebase.sv
`timescale 1ns/1ps
module fss_timebase
    import fss_pkg::*;
#(
    parameter int CYC_W = 12,
    parameter int LIN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             field_start,
    input  logic             line_ref,
    output logic             fs_rise,
    output logic             line_rise,
    output logic             running,
    output logic [CYC_W-1:0] cl_q,
    output logic [LIN_W-1:0] lc_q,
    output logic [CYC_W-1:0] nxt_cl,
    output logic [LIN_W-1:0] nxt_lc
);
    localparam logic [CYC_W-1:0] CL_MAX = {CYC_W{1'b1}};
    localparam logic [LIN_W-1:0] LC_MAX = {LIN_W{1'b1}};

    tb_state_e tb_q, tb_nxt;
    logic      fs_d, lr_d;

    assign fs_rise   = field_start & ~fs_d;
    assign line_rise = line_ref & ~lr_d;

    always_comb begin
        tb_nxt = tb_q;
        nxt_cl = cl_q;
        nxt_lc = lc_q;
        unique case (tb_q)
            TB_IDLE: begin
                if (fs_rise) begin
                    tb_nxt = TB_RUN;
                    nxt_cl = '0;
                    nxt_lc = '0;
                end
            end
            TB_RUN: begin
                if (fs_rise) begin
                    nxt_cl = '0;
                    nxt_lc = '0;
                end else if (line_rise) begin
                    nxt_cl = '0;
                    nxt_lc = (lc_q == LC_MAX) ? lc_q : lc_q + 1'b1;
                end else begin
                    nxt_cl = (cl_q == CL_MAX) ? cl_q : cl_q + 1'b1;
                end
            end
            default: tb_nxt = TB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb_q <= TB_IDLE;
            fs_d <= 1'b0;
            lr_d <= 1'b0;
            cl_q <= '0;
            lc_q <= '0;
        end else begin
            tb_q <= tb_nxt;
            fs_d <= field_start;
            lr_d <= line_ref;
            cl_q <= nxt_cl;
            lc_q <= nxt_lc;
        end
    end

    always_comb running = (tb_q == TB_RUN);

    // R2: a field edge clears both counts
    a_r2_field_clears: assert property (@(posedge clk) disable iff (!rst_n)
        fs_rise |=> (cl_q == '0 && lc_q == '0 && running));

    // R8: a line edge inside a field restarts the cycle count
    a_r8_line_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (line_rise && !fs_rise && running) |=> (cl_q == '0));
endmodule

// File: rtl/fss_channel.sv
`timescale 1ns/1ps
module fss_channel
    import fss_pkg::*;
#(
    parameter int CYC_W = 12,
    parameter int LIN_W = 4,
    parameter int SH_W  = 8,
    parameter int BASE  = 62,
    parameter int LINES = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs_rise,
    input  logic             line_rise,
    input  logic [CYC_W-1:0] nxt_cl,
    input  logic [LIN_W-1:0] nxt_lc,
    input  logic [CYC_W-1:0] cl_q,
    input  logic [LIN_W-1:0] lc_q,
    input  logic [SH_W-1:0]  shift_in,
    input  logic [CYC_W-1:0] len_in,
    output logic             en
);
    localparam logic [CYC_W-1:0] BASE_V  = CYC_W'(BASE);
    localparam logic [LIN_W-1:0] LINES_V = LIN_W'(LINES);

    ch_state_e        st_q, st_nxt, start_st;
    logic [CYC_W-1:0] off_q, len_q, off_now, len_now;
    logic [CYC_W:0]   stop_pt;
    logic             hit, fin, new_line;

    always_comb begin
        off_now  = fs_rise ? (BASE_V + CYC_W'(shift_in)) : off_q;
        len_now  = fs_rise ? len_in : len_q;
        stop_pt  = {1'b0, off_now} + {1'b0, len_now};
        hit      = (nxt_cl == off_now) && (nxt_lc >= LINES_V);
        fin      = ({1'b0, nxt_cl} == stop_pt);
        new_line = fs_rise | line_rise;
        start_st = (len_now != '0) ? CH_ON : CH_REST;
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            CH_IDLE: if (fs_rise)  st_nxt = hit ? start_st : CH_ARM;
            CH_ARM:  if (hit)      st_nxt = start_st;
            CH_ON: begin
                if (new_line)      st_nxt = hit ? start_st : CH_ARM;
                else if (fin)      st_nxt = CH_REST;
            end
            CH_REST: if (new_line) st_nxt = hit ? start_st : CH_ARM;
            default:               st_nxt = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CH_IDLE;
            off_q <= '0;
            len_q <= '0;
        end else begin
            st_q <= st_nxt;
            if (fs_rise) begin
                off_q <= off_now;
                len_q <= len_now;
            end
        end
    end

    always_comb en = (st_q == CH_ON);

    // R5 / R6: no strobe before its line wait has elapsed
    a_r6_lines_waited: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (lc_q >= LINES_V));

    // R7: a high strobe lies inside its offset window of the current line
    a_r7_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cl_q >= off_q && {1'b0, cl_q} < ({1'b0, off_q} + {1'b0, len_q})));

    // R10: captured settings only move at a field edge
    a_r10_settings_held: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_rise |=> ($stable(off_q) && $stable(len_q)));

    // R11: a field edge leaves the strobe low unless its offset is zero
    a_r11_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_rise && off_now != '0) |=> !en);
endmodule

// File: rtl/field_strobe_seq.sv
`timescale 1ns/1ps
module field_strobe_seq
    import fss_pkg::*;
#(
    parameter int CYC_W     = 12,
    parameter int LIN_W     = 4,
    parameter int SH_W      = 8,
    parameter int BASE_C    = 62,
    parameter int BASE_A    = 93,
    parameter int BASE_OUT  = 147,
    parameter int BASE_B    = 159,
    parameter int LINES_OUT = 3,
    parameter int LINES_B   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             field_start,
    input  logic             line_ref,
    input  logic [SH_W-1:0]  shift_a,
    input  logic [SH_W-1:0]  shift_b,
    input  logic [SH_W-1:0]  shift_c,
    input  logic [CYC_W-1:0] active_len,
    output logic             rd_en_a,
    output logic             rd_en_c,
    output logic             wr_en_b,
    output logic             out_active
);
    logic                       fs_rise, line_rise, running;
    logic [CYC_W-1:0]           cl_q, nxt_cl;
    logic [LIN_W-1:0]           lc_q, nxt_lc;
    logic [NCH-1:0][SH_W-1:0]   sh_v;
    logic [NCH-1:0]             en_v;

    assign sh_v = {shift_b, {SH_W{1'b0}}, shift_a, shift_c};

    fss_timebase #(.CYC_W(CYC_W), .LIN_W(LIN_W)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .field_start(field_start),
        .line_ref   (line_ref),
        .fs_rise    (fs_rise),
        .line_rise  (line_rise),
        .running    (running),
        .cl_q       (cl_q),
        .lc_q       (lc_q),
        .nxt_cl     (nxt_cl),
        .nxt_lc     (nxt_lc)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int CH_BASE  = (g == IDX_C) ? BASE_C :
                                  (g == IDX_A) ? BASE_A :
                                  (g == IDX_O) ? BASE_OUT : BASE_B;
        localparam int CH_LINES = (g == IDX_O) ? LINES_OUT :
                                  (g == IDX_B) ? LINES_B : 0;
        fss_channel #(
            .CYC_W(CYC_W), .LIN_W(LIN_W), .SH_W(SH_W),
            .BASE(CH_BASE), .LINES(CH_LINES)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .fs_rise  (fs_rise),
            .line_rise(line_rise),
            .nxt_cl   (nxt_cl),
            .nxt_lc   (nxt_lc),
            .cl_q     (cl_q),
            .lc_q     (lc_q),
            .shift_in (sh_v[g]),
            .len_in   (active_len),
            .en       (en_v[g])
        );
    end

    always_comb begin
        rd_en_c    = en_v[IDX_C];
        rd_en_a    = en_v[IDX_A];
        out_active = en_v[IDX_O];
        wr_en_b    = en_v[IDX_B];
    end

    // R1: nothing asserts before the first field edge
    a_r1_quiet_before_field: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (en_v == '0));
endmodule

// File: tb/field_strobe_seq_tb_top.sv
`timescale 1ns/1ps
module field_strobe_seq_tb_top;
    localparam int CMAX = 4095;
    localparam int LMAX = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fs = 1'b0, lr = 1'b0;
    logic [7:0]  sa = '0, sb = '0, sc = '0;
    logic [11:0] alen = '0;
    logic        rd_en_a, rd_en_c, wr_en_b, out_active;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // bench model of the counts
    bit m_run = 0, m_fsp = 0, m_lrp = 0;
    int m_cl = 0, m_lc = 0, m_oc = 0, m_oa = 0, m_ob = 0, m_len = 0;

    always #5 clk = ~clk;

    field_strobe_seq dut_i (
        .clk(clk), .rst_n(rst_n), .field_start(fs), .line_ref(lr),
        .shift_a(sa), .shift_b(sb), .shift_c(sc), .active_len(alen),
        .rd_en_a(rd_en_a), .rd_en_c(rd_en_c), .wr_en_b(wr_en_b),
        .out_active(out_active)
    );

    function automatic bit exp_en(int wait_lines, int off);
        return m_run && (m_lc >= wait_lines) && (m_cl >= off) && (m_cl < off + m_len);
    endfunction

    task automatic chk(string req, string phase, bit got, bit exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] t=%0t got %b expected %b", req, phase, $time, got, exp);
        end
    endtask

    task automatic check_all(string phase);
        chk("R3 rd_en_c",    phase, rd_en_c,    exp_en(0, m_oc));
        chk("R4 rd_en_a",    phase, rd_en_a,    exp_en(0, m_oa));
        chk("R5 out_active", phase, out_active, exp_en(3, 147));
        chk("R6 wr_en_b",    phase, wr_en_b,    exp_en(4, m_ob));
    endtask

    task automatic model_step();
        bit fsr, lrr;
        fsr = fs && !m_fsp;
        lrr = lr && !m_lrp;
        m_fsp = fs;
        m_lrp = lr;
        if (fsr) begin
            m_run = 1; m_cl = 0; m_lc = 0;
            m_oc = 62 + int'(sc);
            m_oa = 93 + int'(sa);
            m_ob = 159 + int'(sb);
            m_len = int'(alen);
        end else if (m_run) begin
            if (lrr) begin
                m_cl = 0;
                m_lc = (m_lc < LMAX) ? m_lc + 1 : m_lc;
            end else begin
                m_cl = (m_cl < CMAX) ? m_cl + 1 : m_cl;
            end
        end
    endtask

    task automatic cyc(bit f, bit l, string phase);
        @(negedge clk);
        check_all(phase);
        fs = f;
        lr = l;
        model_step();
    endtask

    task automatic run_field(int nl, int ll, int fw, int lw, int chg_at, int stop_at, string phase);
        for (int i = 0; i < nl * ll; i++) begin
            if (stop_at > 0 && i == stop_at) break;
            if (i == chg_at) begin
                sa = 8'($urandom); sb = 8'($urandom); sc = 8'($urandom);
                alen = 12'($urandom_range(1, 300));
            end
            cyc(i < fw, (i >= ll) && ((i % ll) < lw), phase);
        end
    endtask

    task automatic setup(int a, int b, int c, int len);
        @(negedge clk);
        check_all("setup");
        sa = 8'(a); sb = 8'(b); sc = 8'(c); alen = 12'(len);
        model_step();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog R1..all got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: outputs low during reset
        repeat (3) begin
            @(negedge clk);
            chk("R1 reset", "reset", rd_en_a | rd_en_c | wr_en_b | out_active, 1'b0);
        end
        rst_n = 1'b1;
        // R1: line_ref activity before any field is ignored
        for (int i = 0; i < 300; i++) cyc(1'b0, (i % 60) < 3, "R1 pre-field");

        // R3 R4 R5 R6: zero shifts, short pulses
        setup(0, 0, 0, 10);
        run_field(6, 400, 4, 2, -1, 0, "R3 R4 R5 R6 zero shift");
        // shift extremes
        setup(255, 255, 255, 5);
        run_field(6, 500, 4, 2, -1, 0, "R3 R4 R6 shift 255");
        // R7: zero length never asserts
        setup(10, 20, 30, 0);
        run_field(6, 350, 3, 1, -1, 0, "R7 zero length");
        // R7: one-cycle pulse
        setup(1, 2, 3, 1);
        run_field(6, 350, 3, 1, -1, 0, "R7 one cycle");
        // R9: pulse longer than the line is cut by the line edge
        setup(0, 0, 0, 1000);
        run_field(6, 300, 3, 2, -1, 0, "R9 cut by line");
        // R2: field_start held high over many cycles
        setup(7, 9, 11, 40);
        run_field(6, 400, 150, 2, -1, 0, "R2 long field pulse");
        // R10: settings changed mid-field
        setup(4, 5, 6, 30);
        run_field(6, 400, 3, 2, 200, 0, "R10 mid-field change");
        run_field(6, 400, 3, 2, -1, 0, "R10 next field");
        // R11: restart inside an active field (while a strobe is high)
        setup(0, 0, 0, 50);
        run_field(6, 400, 3, 2, -1, 1290, "R11 aborted field");
        run_field(6, 400, 3, 2, -1, 0, "R11 restarted field");

        // R8: random fields
        for (int k = 0; k < 12; k++) begin
            int ll, nl;
            ll = $urandom_range(200, 500);
            nl = $urandom_range(5, 7);
            setup($urandom_range(0, 255), $urandom_range(0, 255),
                  $urandom_range(0, 255), $urandom_range(0, 300));
            run_field(nl, ll, $urandom_range(1, 20), $urandom_range(1, 8),
                      ($urandom_range(0, 3) == 0) ? $urandom_range(30, ll) : -1,
                      ($urandom_range(0, 3) == 0) ? $urandom_range(ll, 3 * ll) : 0,
                      "R8 random");
        end
        for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0, "R8 tail");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule